// File: doc/BRIEF.md
# Ratio-Coded Clock Divider

This block produces a slower clock from a fast input clock. The division ratio comes from a 4-bit code. The two low bits of the code pick a base divisor. The two high bits scale that base by a power of two. A table-select input switches between two sets of base divisors, so the block covers both even and odd ratios from 2 up to 72.

Every ratio, odd ratios included, gives a 50% duty cycle. A falling-edge stage adds the missing half cycle when the ratio is odd. An invert input flips the polarity of the divided clock, and an enable input starts and stops it. A stopped output sits low.

All mode inputs (code, table select, invert, enable) are sampled only at the boundary between two output periods. As a result the output never shows a shortened pulse or a partial period. The block is meant to sit beside a clock source as a programmable output stage.

Top module: `ratio_clkdiv`

## Requirements
- R1: With `alt_table` = 0, code bits [1:0] select base divisor 2 (00), 3 (01), 5 (10) or 7 (11).
- R2: With `alt_table` = 1, code bits [1:0] select base divisor 4 (00), 3 (01), 5 (10) or 9 (11). The resulting ratios span 3 to 72.
- R3: Code bits [3:2] scale the base by 1 (00), 2 (01), 4 (10) or 8 (11). The division ratio N equals the base shifted left by that field. For example, code 1111 in the first table gives 56.
- R4: While running, each output period lasts N input clock cycles. The output is high for the first N half-cycles and low for the last N half-cycles, so the duty cycle is 50% for odd N as well. Each period begins at a rising input clock edge.
- R5: With invert sampled as 1, the running output is the complement of the R4 pattern: low for the first N half-cycles and high for the last N half-cycles.
- R6: A change of code or table select takes effect only at the next period boundary. The period in progress completes with the old ratio.
- R7: Enable and invert are sampled only at period boundaries. A period in which enable was sampled 0 is held low for all of its 2N half-cycles, whatever the invert setting. Stopping and restarting therefore occur only on whole periods.
- R8: While `rst` is high at a rising edge, the output is low. The first period after release starts at the first rising edge with `rst` low, counting from zero, and uses the inputs present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock; both edges are used |
| rst | input | 1 | Synchronous reset, active high |
| ratio_code | input | 4 | Bits [1:0] base select, bits [3:2] power-of-two scale |
| alt_table | input | 1 | 0 selects the first base table, 1 the alternate table |
| invert | input | 1 | 1 inverts the divided output polarity |
| enable | input | 1 | 1 runs the output, 0 parks it low |
| clk_out | output | 1 | Divided clock |

## Verification
The case of interest is a ratio change and an enable drop that both arrive at the same period boundary. The bench provokes it by moving the code from ratio 7 to ratio 2 and dropping enable in the last cycle of a ratio-7 period. It then raises enable again part-way through the following short period. It judges the result half-cycle by half-cycle. The ratio-7 period must finish whole, exactly one ratio-2 period must stay low, and the output must then resume with the ratio-2 pattern starting from its high phase. The same judgement, with different timing, covers a mid-period enable drop, ratio and polarity changes between boundaries, and a full sweep of both tables in both polarities.

// File: rtl/rcd_pkg.sv
package rcd_pkg;
  localparam int BASE_SEL_W = 2;
  localparam int MUL_SEL_W  = 2;
  localparam int CODE_W     = BASE_SEL_W + MUL_SEL_W;
  localparam int MUL_STEPS  = 1 << MUL_SEL_W;
  localparam int MAX_BASE   = 9;
  localparam int MAX_RATIO  = MAX_BASE << (MUL_STEPS - 1);
  localparam int RATIO_W    = $clog2(MAX_RATIO + 1);

  typedef logic [RATIO_W-1:0] ratio_t;

  // Settings held for one output period
  typedef struct packed {
    ratio_t last;      // N - 1, terminal count
    ratio_t high_len;  // floor(N/2), cycles the leading stage stays high
    logic   odd;       // N is odd: falling-edge stage stretches the pulse
  } div_cfg_t;

  function automatic ratio_t base_of(input logic [BASE_SEL_W-1:0] sel,
                                     input logic alt);
    ratio_t b;
    case ({alt, sel})
      3'b000:  b = ratio_t'(2);
      3'b001:  b = ratio_t'(3);
      3'b010:  b = ratio_t'(5);
      3'b011:  b = ratio_t'(7);
      3'b100:  b = ratio_t'(4);
      3'b101:  b = ratio_t'(3);
      3'b110:  b = ratio_t'(5);
      default: b = ratio_t'(9);
    endcase
    return b;
  endfunction
endpackage

// File: rtl/rcd_ratio_decode.sv
module rcd_ratio_decode
  import rcd_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic              alt,
  output div_cfg_t          cfg
);
  ratio_t base;
  ratio_t scaled [MUL_STEPS];
  ratio_t ratio;

  always_comb base = base_of(code[BASE_SEL_W-1:0], alt);

  // One candidate per power-of-two scale
  for (genvar k = 0; k < MUL_STEPS; k++) begin : g_scale
    assign scaled[k] = ratio_t'(base << k);
  end

  assign ratio = scaled[code[CODE_W-1:BASE_SEL_W]];

  always_comb begin
    cfg.last     = ratio - ratio_t'(1);
    cfg.high_len = ratio >> 1;
    cfg.odd      = ratio[0];
  end
endmodule

// File: rtl/rcd_period_counter.sv
module rcd_period_counter
  import rcd_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  div_cfg_t cfg_in,
  input  logic     en_in,
  input  logic     inv_in,
  output ratio_t   cnt_q,
  output div_cfg_t cfg_q,
  output logic     run_q,
  output logic     inv_q,
  output logic     wrap,
  output ratio_t   cnt_d,
  output ratio_t   hlen_d
);
  // Reset leaves last = 0, so the first edge after release is a boundary
  assign wrap = (cnt_q == cfg_q.last);

  always_comb begin
    cnt_d  = wrap ? '0 : cnt_q + ratio_t'(1);
    hlen_d = wrap ? cfg_in.high_len : cfg_q.high_len;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      cfg_q <= '0;
      run_q <= 1'b0;
      inv_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (wrap) begin
        cfg_q <= cfg_in;
        run_q <= en_in;
        inv_q <= inv_in;
      end
    end
  end
endmodule

// File: rtl/rcd_wave_shaper.sv
module rcd_wave_shaper
  import rcd_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  ratio_t cnt_d,
  input  ratio_t hlen_d,
  input  logic   odd,
  input  logic   run,
  input  logic   inv,
  output logic   wave
);
  logic lead_q;   // rising-edge stage, high for floor(N/2) cycles
  logic trail_q;  // same waveform half a cycle later

  always_ff @(posedge clk) begin
    if (rst) lead_q <= 1'b0;
    else     lead_q <= (cnt_d < hlen_d);
  end

  always_ff @(negedge clk) begin
    if (rst) trail_q <= 1'b0;
    else     trail_q <= lead_q;
  end

  // Odd N: the trailing copy extends the high phase by half a cycle
  assign wave = run & ((lead_q | (odd & trail_q)) ^ inv);
endmodule

// File: rtl/ratio_clkdiv.sv
module ratio_clkdiv
  import rcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] ratio_code,
  input  logic              alt_table,
  input  logic              invert,
  input  logic              enable,
  output logic              clk_out
);
  div_cfg_t cfg_new;
  div_cfg_t cfg_q;
  ratio_t   cnt_q;
  ratio_t   cnt_d;
  ratio_t   hlen_d;
  logic     run_q;
  logic     inv_q;
  logic     wrap;

  rcd_ratio_decode u_decode (
    .code (ratio_code),
    .alt  (alt_table),
    .cfg  (cfg_new)
  );

  rcd_period_counter u_count (
    .clk    (clk),
    .rst    (rst),
    .cfg_in (cfg_new),
    .en_in  (enable),
    .inv_in (invert),
    .cnt_q  (cnt_q),
    .cfg_q  (cfg_q),
    .run_q  (run_q),
    .inv_q  (inv_q),
    .wrap   (wrap),
    .cnt_d  (cnt_d),
    .hlen_d (hlen_d)
  );

  rcd_wave_shaper u_shape (
    .clk    (clk),
    .rst    (rst),
    .cnt_d  (cnt_d),
    .hlen_d (hlen_d),
    .odd    (cfg_q.odd),
    .run    (run_q),
    .inv    (inv_q),
    .wave   (clk_out)
  );
endmodule

// File: rtl/rcd_checker.sv
module rcd_checker
  import rcd_pkg::*;
(
  input logic     clk,
  input logic     rst,
  input logic     wrap,
  input ratio_t   cnt_q,
  input div_cfg_t cfg_q,
  input logic     run_q,
  input logic     inv_q
);
  // R6
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(cfg_q));

  // R7
  run_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(run_q));

  // R5
  inv_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(inv_q));

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= cfg_q.last);

  // R8
  restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt_q == '0));

  // R3
  ratio_range_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cfg_q.last >= ratio_t'(1) && cfg_q.last <= ratio_t'(MAX_RATIO - 1)));
endmodule

bind ratio_clkdiv rcd_checker chk_i (
  .clk   (clk),
  .rst   (rst),
  .wrap  (wrap),
  .cnt_q (cnt_q),
  .cfg_q (cfg_q),
  .run_q (run_q),
  .inv_q (inv_q)
);

// File: tb/ratio_clkdiv_tb_top.sv
module ratio_clkdiv_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] ratio_code = 4'd0;
  logic       alt_table = 1'b0;
  logic       invert = 1'b0;
  logic       enable = 1'b1;
  logic       clk_out;

  always #5 clk = ~clk;

  ratio_clkdiv dut_i (
    .clk        (clk),
    .rst        (rst),
    .ratio_code (ratio_code),
    .alt_table  (alt_table),
    .invert     (invert),
    .enable     (enable),
    .clk_out    (clk_out)
  );

  int   checks = 0;
  int   errors = 0;
  logic obs  [0:2047];
  logic expv [0:2047];

  // Ratio from R1, R2, R3
  function automatic int ref_ratio(input logic [3:0] c, input logic a);
    int b;
    case (c[1:0])
      2'b00:   b = a ? 4 : 2;
      2'b01:   b = 3;
      2'b10:   b = 5;
      default: b = a ? 9 : 7;
    endcase
    return b << c[3:2];
  endfunction

  // Expected half-cycle pattern per R4, R5, R7
  task automatic fill(input int from, input int n, input int nper,
                      input bit run, input bit inv);
    for (int p = 0; p < nper; p++)
      for (int h = 0; h < 2 * n; h++)
        expv[from + p * 2 * n + h] = run ? ((h < n) ^ inv) : 1'b0;
  endtask

  // Reset, check R8 low output, release; returns at the first period edge
  task automatic start(input logic [3:0] c, input logic a,
                       input logic v, input logic e);
    ratio_code = c;
    alt_table  = a;
    invert     = v;
    enable     = e;
    rst        = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (clk_out !== 1'b0) begin
      errors++;
      $display("FAIL R8: output during reset = %b, expected 0", clk_out);
    end
    rst = 1'b0;
    @(posedge clk);
  endtask

  task automatic capture(input int nh);
    #2.5;
    for (int h = 0; h < nh; h++) begin
      obs[h] = clk_out;
      #5;
    end
  endtask

  task automatic judge(input string tag, input int nh);
    int bad;
    bad = -1;
    checks++;
    for (int h = 0; h < nh; h++)
      if (bad < 0 && obs[h] !== expv[h]) bad = h;
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s: half-cycle %0d out=%b expected %b",
               tag, bad, obs[bad], expv[bad]);
    end
  endtask

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 R2 R3 R4 R5: both tables, every code, both polarities, two periods
    for (int a = 0; a < 2; a++)
      for (int c = 0; c < 16; c++)
        for (int v = 0; v < 2; v++) begin
          int n;
          n = ref_ratio(4'(c), a[0]);
          start(4'(c), a[0], v[0], 1'b1);
          fill(0, n, 2, 1'b1, v[0]);
          capture(4 * n);
          judge($sformatf("%s%s code=%0d N=%0d",
                          a ? "R2 R3 R4" : "R1 R3 R4", v ? " R5" : "", c, n),
                4 * n);
        end

    // R7: enable dropped mid-period at ratio 5, restored later
    start(4'b0010, 1'b0, 1'b0, 1'b1);
    fork
      capture(60);
      begin
        repeat (2) @(posedge clk);
        #2.5 enable = 1'b0;
        repeat (15) @(posedge clk);
        #2.5 enable = 1'b1;
      end
    join
    fill(0, 5, 1, 1'b1, 1'b0);
    fill(10, 5, 3, 1'b0, 1'b0);
    fill(40, 5, 2, 1'b1, 1'b0);
    judge("R7 stop and restart on whole periods", 60);

    // R6 R5: ratio 3 -> 10 and polarity change mid-period
    start(4'b0001, 1'b0, 1'b0, 1'b1);
    fork
      capture(46);
      begin
        repeat (1) @(posedge clk);
        #2.5;
        ratio_code = 4'b0110;
        invert     = 1'b1;
      end
    join
    fill(0, 3, 1, 1'b1, 1'b0);
    fill(6, 10, 2, 1'b1, 1'b1);
    judge("R6 R5 deferred ratio and polarity", 46);

    // R6 R2: table switch mid-period, ratio 2 -> 4
    start(4'b0000, 1'b0, 1'b0, 1'b1);
    fork
      capture(20);
      begin
        #2.5 alt_table = 1'b1;
      end
    join
    fill(0, 2, 1, 1'b1, 1'b0);
    fill(4, 4, 2, 1'b1, 1'b0);
    judge("R6 R2 deferred table switch", 20);

    // R6 R7: ratio change and enable drop at the same boundary
    start(4'b0011, 1'b0, 1'b0, 1'b1);
    fork
      capture(34);
      begin
        repeat (6) @(posedge clk);
        #2.5;
        ratio_code = 4'b0000;
        enable     = 1'b0;
        repeat (2) @(posedge clk);
        #2.5 enable = 1'b1;
      end
    join
    fill(0, 7, 1, 1'b1, 1'b0);
    fill(14, 2, 1, 1'b0, 1'b0);
    fill(18, 2, 4, 1'b1, 1'b0);
    judge("R6 R7 same-boundary ratio and enable", 34);

    // R7 R5: disabled output stays low even when inverted
    start(4'b0101, 1'b0, 1'b1, 1'b0);
    fill(0, 6, 3, 1'b0, 1'b1);
    capture(36);
    judge("R7 R5 disabled inverted output low", 36);

    // R8: reset in the middle of a long period restarts from zero
    start(4'b1111, 1'b1, 1'b0, 1'b1);
    repeat (20) @(posedge clk);
    start(4'b0001, 1'b1, 1'b0, 1'b1);
    fill(0, 3, 3, 1'b1, 1'b0);
    capture(18);
    judge("R8 restart after mid-period reset", 18);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule